// File: doc/BRIEF.md
# Two-Client Shared LIFO

This block is a last-in first-out store shared by two clients. Each client has its own request channel and its own response channel, both using a valid/ready handshake. A client places a push or a pop on its request channel. When the block takes it, the block updates the shared stack on that clock edge. In the next cycle it raises a completion on that client's response channel. A pop returns the word removed from the top of the stack.

Each client may have only one operation in flight. A port lowers its request ready while its own completion has not yet been taken. When both clients request in the same cycle, client 0 is served and client 1 waits. A push into a full stack is dropped but still completes normally. A pop from an empty stack completes with zero data. Data width and stack depth are parameters, set to 8 bits and 16 entries by default.

Top module: `twin_port_lifo`

## Requirements
- R1: After reset, both response valids are low, both request readys are high and the stack is empty.
- R2: A request is taken only on a clock edge where its valid and ready are both high. A port's request ready stays low while that port's response is pending, so a request offered then has no effect on the stack.
- R3: A taken request produces a response valid on the same port in the following cycle. The response command is 2 for a push (request command 0) and 3 for a pop (request command 1).
- R4: While a response valid is high and its ready is low, response valid, data and command hold their values.
- R5: A pop returns the most recently pushed word that is still stored, so pushes come back in reverse order.
- R6: When both ports offer requests in the same cycle, port 0 is taken and port 1's ready is low in that cycle. Port 1's request is taken on a later edge.
- R7: A push into a stack that already holds DEPTH words leaves the contents unchanged and still completes with command 2.
- R8: A pop from an empty stack completes with command 3 and all-zero data.
- R9: A push completion carries all-zero data.
- R10: Both ports act on one stack, so a word pushed through one port can be popped through the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 2 | Request valid, one bit per port |
| inReady | output | 2 | Request ready, one bit per port |
| inCmd | input | 2 | Request command per port: 0 push, 1 pop |
| inData | input | 2 x DATA_W | Push word per port |
| outValid | output | 2 | Response valid per port |
| outReady | input | 2 | Response ready per port |
| outCmd | output | 2 x 2 | Response code per port: 2 push done, 3 pop done |
| outData | output | 2 x DATA_W | Popped word per port, zero for pushes |

## Verification
A request counts as taken on the rising edge where valid and ready are both high. The stack changes on that same edge, and the response is due one edge later: it is visible from the falling edge that follows the accepting rising edge. The bench drives inputs on falling edges and reads request ready a moment after driving, because ready depends on the other port's valid in the same cycle. It looks for the completion on the first falling edge after acceptance, then re-samples it on each later falling edge while response ready is held low. A reference stack in the bench is updated at each accepting edge, in acceptance order, and it gives the expected word for every pop.

// File: rtl/twin_lifo_pkg.sv
package twin_lifo_pkg;

  localparam int NUM_PORTS = 2;

  // request command bit
  localparam logic REQ_PUSH = 1'b0;
  localparam logic REQ_POP  = 1'b1;

  // response completion codes
  typedef enum logic [1:0] {
    RSP_PUSH_DONE = 2'd2,
    RSP_POP_DONE  = 2'd3
  } rspCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store the winner's word at slotAddr
    logic loadResp;  // capture response data for the winner
    logic winner;    // port index served this cycle
    logic zeroResp;  // response data is zero (push, or pop of empty)
  } lifoStrobe_t;

endpackage

// File: rtl/twin_lifo_ctrl.sv
module twin_lifo_ctrl
  import twin_lifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PORTS-1:0]           inValid,
  input  logic [NUM_PORTS-1:0]           inCmd,
  input  logic [NUM_PORTS-1:0]           outReady,
  output logic [NUM_PORTS-1:0]           inReady,
  output logic [NUM_PORTS-1:0]           outValid,
  output logic [NUM_PORTS-1:0][1:0]      outCmd,
  output lifoStrobe_t                    strobe,
  output logic [AW-1:0]                  slotAddr,
  output logic [CW-1:0]                  stackCount
);

  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

  logic [NUM_PORTS-1:0] pend;
  logic [NUM_PORTS-1:0] popFlag;
  logic [NUM_PORTS-1:0] fire;
  logic [CW-1:0]        count;
  logic [CW-1:0]        addrWide;
  logic                 anyFire;
  logic                 winner;
  logic                 opPop;
  logic                 isFull;
  logic                 isEmpty;

  // ready: no own pending response; port 1 also yields to a live port 0 offer
  always_comb begin
    inReady[0] = ~pend[0];
    inReady[1] = ~pend[1] & ~(inValid[0] & ~pend[0]);
  end

  assign fire    = inValid & inReady;
  assign anyFire = |fire;
  assign winner  = ~fire[0];
  assign opPop   = (inCmd[winner] == REQ_POP);
  assign isFull  = (count == FULL_COUNT);
  assign isEmpty = (count == '0);

  always_comb begin
    addrWide = opPop ? (count - CW'(1)) : count;
    slotAddr = addrWide[AW-1:0];
  end

  always_comb begin
    strobe.wrEn     = anyFire & ~opPop & ~isFull;
    strobe.loadResp = anyFire;
    strobe.winner   = winner;
    strobe.zeroResp = ~opPop | isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (anyFire) begin
      if (!opPop && !isFull) begin
        count <= count + CW'(1);
      end else if (opPop && !isEmpty) begin
        count <= count - CW'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[i]    <= 1'b0;
        popFlag[i] <= 1'b0;
      end else if (fire[i]) begin
        pend[i]    <= 1'b1;
        popFlag[i] <= opPop;
      end else if (pend[i] && outReady[i]) begin
        pend[i]    <= 1'b0;
      end
    end

    assign outValid[i] = pend[i];
    assign outCmd[i]   = popFlag[i] ? RSP_POP_DONE : RSP_PUSH_DONE;
  end

  assign stackCount = count;

endmodule

// File: rtl/twin_lifo_dpath.sv
module twin_lifo_dpath
  import twin_lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  lifoStrobe_t                        strobe,
  input  logic [AW-1:0]                      slotAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   inData,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   outData
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] topWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      store[slotAddr] <= inData[strobe.winner];
    end
  end

  assign topWord = store[slotAddr];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_resp
    logic [DATA_W-1:0] respWord;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        respWord <= '0;
      end else if (strobe.loadResp && (strobe.winner == 1'(i))) begin
        respWord <= strobe.zeroResp ? '0 : topWord;
      end
    end
    assign outData[i] = respWord;
  end

endmodule

// File: rtl/twin_port_lifo.sv
module twin_port_lifo
  import twin_lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               inValid,
  output logic [1:0]               inReady,
  input  logic [1:0]               inCmd,
  input  logic [1:0][DATA_W-1:0]   inData,
  output logic [1:0]               outValid,
  input  logic [1:0]               outReady,
  output logic [1:0][1:0]          outCmd,
  output logic [1:0][DATA_W-1:0]   outData
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  lifoStrobe_t   strobe;
  logic [AW-1:0] slotAddr;
  logic [CW-1:0] stackCount;

  twin_lifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inCmd      (inCmd),
    .outReady   (outReady),
    .inReady    (inReady),
    .outValid   (outValid),
    .outCmd     (outCmd),
    .strobe     (strobe),
    .slotAddr   (slotAddr),
    .stackCount (stackCount)
  );

  twin_lifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotAddr (slotAddr),
    .inData   (inData),
    .outData  (outData)
  );

endmodule

// File: rtl/twin_port_lifo_chk.sv
module twin_port_lifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             inValid,
  input logic [1:0]             inReady,
  input logic [1:0]             inCmd,
  input logic [1:0]             outValid,
  input logic [1:0]             outReady,
  input logic [1:0][1:0]        outCmd,
  input logic [1:0][DATA_W-1:0] outData,
  input logic [CW-1:0]          stackCount
);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rstN)
      outValid[i] |-> !inReady[i]);

    assert_resp_next_R3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inReady[i]) |=> outValid[i]);

    assert_resp_code_R3: assert property (@(posedge clk) disable iff (!rstN)
      outValid[i] |-> (outCmd[i] == 2'd2 || outCmd[i] == 2'd3));

    assert_resp_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[i] && !outReady[i]) |=>
        (outValid[i] && $stable(outData[i]) && $stable(outCmd[i])));

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inReady[i] && inCmd[i] && stackCount == '0) |=>
        (outData[i] == '0 && outCmd[i] == 2'd3));
  end

  assert_one_taken_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid[0] && inReady[0]) |-> !(inValid[1] && inReady[1]));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    stackCount <= CW'(DEPTH));

  assert_full_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stackCount == CW'(DEPTH) && inValid[0] && inReady[0] && !inCmd[0]) |=>
      (stackCount == CW'(DEPTH)));

endmodule

bind twin_port_lifo twin_port_lifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .inCmd      (inCmd),
  .outValid   (outValid),
  .outReady   (outReady),
  .outCmd     (outCmd),
  .outData    (outData),
  .stackCount (stackCount)
);

// File: tb/twin_port_lifo_tb_top.sv
module twin_port_lifo_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [1:0]             inValid = '0;
  logic [1:0]             inReady;
  logic [1:0]             inCmd = '0;
  logic [1:0][DATA_W-1:0] inData = '0;
  logic [1:0]             outValid;
  logic [1:0]             outReady = '0;
  logic [1:0][1:0]        outCmd;
  logic [1:0][DATA_W-1:0] outData;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] model [DEPTH];
  int mCount = 0;

  always #4 clk = ~clk;

  twin_port_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inCmd(inCmd), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outCmd(outCmd), .outData(outData)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // update reference stack at the accepting edge, return expected response data
  task automatic modelStep(logic isPop, logic [DATA_W-1:0] d, output logic [DATA_W-1:0] exp);
    exp = '0;
    if (isPop) begin
      if (mCount > 0) begin
        mCount--;
        exp = model[mCount];
      end
    end else if (mCount < DEPTH) begin
      model[mCount] = d;
      mCount++;
    end
  endtask

  // one full operation on port p; nag re-offers a request while the response waits
  task automatic doOp(int p, logic isPop, logic [DATA_W-1:0] d, int hold, bit nag, string req);
    logic [DATA_W-1:0] exp;
    logic [DATA_W-1:0] rd;
    logic [1:0]        rc;
    @(negedge clk);
    inValid[p] = 1'b1;
    inCmd[p]   = isPop;
    inData[p]  = d;
    #1;
    while (!inReady[p]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    modelStep(isPop, d, exp);
    @(negedge clk);
    inValid[p] = 1'b0;
    chk("R3", "response valid one cycle after accept", 32'(outValid[p]), 32'd1);
    rd = outData[p];
    rc = outCmd[p];
    chk("R3", "response code", 32'(rc), isPop ? 32'd3 : 32'd2);
    chk(req, isPop ? "popped word" : "push response data", 32'(rd), 32'(exp));
    for (int k = 0; k < hold; k++) begin
      if (nag) begin
        inValid[p] = 1'b1;
        inCmd[p]   = 1'b0;
        inData[p]  = 8'h77;
      end
      #1;
      chk("R2", "ready low while response pending", 32'(inReady[p]), 32'd0);
      @(negedge clk);
      chk("R4", "valid held", 32'(outValid[p]), 32'd1);
      chk("R4", "data held", 32'(outData[p]), 32'(rd));
      chk("R4", "code held", 32'(outCmd[p]), 32'(rc));
    end
    inValid[p]  = 1'b0;
    outReady[p] = 1'b1;
    @(posedge clk);
    #1;
    outReady[p] = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "response valids after reset", 32'(outValid), 32'd0);
    chk("R1", "request readys after reset", 32'(inReady), 32'd3);
    doOp(1, 1'b1, 8'h00, 0, 1'b0, "R1");  // stack empty: zero data
  endtask

  task automatic testLifoOrder();
    doOp(0, 1'b0, 8'hA1, 0, 1'b0, "R9");
    doOp(0, 1'b0, 8'hB2, 1, 1'b0, "R9");
    doOp(1, 1'b0, 8'hC3, 0, 1'b0, "R9");
    doOp(0, 1'b1, 8'h00, 0, 1'b0, "R5");  // C3 pushed on port 1, popped on port 0
    doOp(1, 1'b1, 8'h00, 2, 1'b0, "R10");
    doOp(1, 1'b1, 8'h00, 0, 1'b0, "R5");
  endtask

  task automatic testPendingIgnored();
    doOp(0, 1'b0, 8'h33, 3, 1'b1, "R9");   // 0x77 offered while pending must not land
    doOp(0, 1'b1, 8'h00, 0, 1'b0, "R2");   // expect 0x33
    doOp(0, 1'b1, 8'h00, 0, 1'b0, "R8");   // expect zero: stack empty again
  endtask

  task automatic testPriority();
    logic [DATA_W-1:0] e;
    @(negedge clk);
    inValid   = 2'b11;
    inCmd     = 2'b00;
    inData[0] = 8'h5A;
    inData[1] = 8'hC6;
    #1;
    chk("R6", "readys on conflict (port 0 wins)", 32'(inReady), 32'd1);
    @(posedge clk);
    modelStep(1'b0, 8'h5A, e);
    @(negedge clk);
    inValid[0] = 1'b0;
    chk("R6", "only port 0 answered", 32'(outValid), 32'd1);
    #1;
    chk("R6", "port 1 ready after port 0 served", 32'(inReady[1]), 32'd1);
    @(posedge clk);
    modelStep(1'b0, 8'hC6, e);
    @(negedge clk);
    inValid[1] = 1'b0;
    chk("R6", "both answered", 32'(outValid), 32'd3);
    outReady = 2'b11;
    @(posedge clk);
    #1;
    outReady = 2'b00;
    doOp(0, 1'b1, 8'h00, 0, 1'b0, "R6");   // C6 on top
    doOp(1, 1'b1, 8'h00, 0, 1'b0, "R10");  // 5A
  endtask

  task automatic testFullEmpty();
    for (int i = 0; i < DEPTH; i++) doOp(0, 1'b0, 8'(8'h10 + i), 0, 1'b0, "R9");
    doOp(0, 1'b0, 8'hEE, 0, 1'b0, "R7");   // dropped, still push code
    doOp(1, 1'b1, 8'h00, 0, 1'b0, "R7");   // top is 0x1F, not 0xEE
    chk("R7", "top after full push", 32'(outData[1]), 32'h1F);
    for (int i = 1; i < DEPTH; i++) doOp(1, 1'b1, 8'h00, 0, 1'b0, "R5");
    doOp(0, 1'b1, 8'h00, 1, 1'b0, "R8");
    doOp(1, 1'b1, 8'h00, 0, 1'b0, "R8");
  endtask

  task automatic portWorker(int p);
    for (int n = 0; n < 20; n++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      doOp(p, (n >= 10), 8'($urandom_range(1, 255)), $urandom_range(0, 2), 1'b0,
           (n >= 10) ? "R10" : "R9");
    end
  endtask

  task automatic testConcurrent();
    fork
      portWorker(0);
      portWorker(1);
    join
    while (mCount > 0) doOp(0, 1'b1, 8'h00, 0, 1'b0, "R5");
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testLifoOrder();
    testPendingIgnored();
    testPriority();
    testFullEmpty();
    testConcurrent();
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule